// File: doc/BRIEF.md
# Load/Store Byte-Overlap Hazard Detector

This block watches a small, fixed number of slots that hold in-flight memory accesses and says, for every slot, whether the slot is clear of every other live slot. A slot is filled by a one-cycle activate strobe. The strobe captures an address and a size code. The slot stays live until a release strobe. The address is split into two parts. The low four bits give a byte offset inside a 16-byte window. The bits above them form a short partial tag. The partial tag is only a slice of the real address, so hazard detection is conservative on that slice alone.

When a slot is filled, its offset and size are turned into a 16-bit byte-presence mask. Two live slots clash when their partial tags are equal and their masks have a set bit in common. Two accesses that fall in the same window but touch different bytes are therefore not serialised. A misaligned access near the top of the window keeps only the bytes that lie inside the window. Any part that would run into the next window is dropped. This can hide a real overlap, but it never invents a false one, which is safe for a scheduler that uses the result only as a hint.

The outputs are combinational from the slot registers. A strobe at one clock edge is visible on the outputs for the whole following cycle. The per-pair matrix lets a scheduler see which other slot blocks a given one.

Top module: `lsovl_detect`

## Requirements
- R1: While and after a synchronous reset with no strobe since, every slot is empty: `clear_o` and `pair_free_o` are all zero.
- R2: Activate on slot k captures that slot's address and size and makes it live from the next cycle. Activating a live slot replaces its stored access. With no strobes, the outputs hold their value.
- R3: Release on slot k empties it from the next cycle. When activate and release hit the same slot in the same cycle, activate wins and the new access is captured.
- R4: A byte access (size code 2'b00) occupies only the byte at offset `addr[3:0]`.
- R5: Size codes 2'b01, 2'b10 and 2'b11 occupy 2, 4 and 8 consecutive bytes, starting at offset `addr[3:0]`.
- R6: Bytes of an access that would lie past byte 15 of the window are dropped. They do not wrap to low bytes and do not cause a clash.
- R7: Two live slots i≠j clash exactly when `addr[PA_W+3:4]` are equal and their occupied byte sets intersect. Different partial tags never clash.
- R8: An empty slot causes no clash: column j of `pair_free_o` is zero while slot j is empty. Its stale contents have no effect, and `clear_o` of an empty slot is zero.
- R9: The diagonal bit `pair_free_o[k*N_SLOT+k]` equals the live state of slot k, so a slot is never compared with itself.
- R10: `pair_free_o[i*N_SLOT+j]` is 1 when slot j is live and does not clash with slot i. `clear_o[i]` is 1 exactly when slot i is live and row i equals the live-slot vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | N_SLOT | Per-slot activate strobe; captures address and size |
| rel_i | input | N_SLOT | Per-slot release strobe |
| addr_i | input | N_SLOT*(PA_W+4) | Per-slot address; slot k at bits k*(PA_W+4) upward, low 4 bits are the byte offset |
| size_i | input | 2*N_SLOT | Per-slot size code, slot k at bits 2k+1:2k |
| clear_o | output | N_SLOT | Slot is live and clashes with no other live slot |
| pair_free_o | output | N_SLOT*N_SLOT | Bit i*N_SLOT+j: slot j live and clear of slot i |

## Verification
The bench fills two slots with every pair of offset and size under a shared tag. This covers the byte case, the multi-byte cases and every access that runs off the top of the window. A mask built as a rotate instead of a shift would report false clashes against low bytes. A wrong size decode would miss adjacent-byte overlaps. Runs with tags that differ, including in the top tag bit only, catch a comparator that drops tag bits. Directed sequences cover activate-over-release priority, overwriting a live slot, stale contents of released slots and the diagonal. A design that lets release win, or that keeps comparing empty slots, would report wrong `clear_o` bits there.

// File: rtl/lsovl_pkg.sv
package lsovl_pkg;

  localparam int OFF_W     = 4;
  localparam int WIN_BYTES = 1 << OFF_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBLW = 2'b11
  } acc_size_e;

  // Mask of the bytes an access of the given size covers at offset zero
  function automatic logic [WIN_BYTES-1:0] span_bits(acc_size_e sz);
    int nbytes;
    nbytes = 1 << int'(sz);
    return WIN_BYTES'((32'd1 << nbytes) - 32'd1);
  endfunction

endpackage

// File: rtl/lsovl_mask_gen.sv
module lsovl_mask_gen
  import lsovl_pkg::*;
(
  input  logic [OFF_W-1:0]     off_i,
  input  acc_size_e            size_i,
  output logic [WIN_BYTES-1:0] mask_o
);

  logic [WIN_BYTES-1:0] span;

  always_comb begin
    span   = span_bits(size_i);
    // Left shift inside the window width: bytes past the top fall away
    mask_o = span << off_i;
  end

endmodule

// File: rtl/lsovl_slot.sv
module lsovl_slot
  import lsovl_pkg::*;
#(
  parameter int PA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_i,
  input  logic                 clr_i,
  input  logic [PA_W-1:0]      tag_i,
  input  logic [WIN_BYTES-1:0] mask_i,
  output logic                 live_o,
  output logic [PA_W-1:0]      tag_o,
  output logic [WIN_BYTES-1:0] mask_o
);

  logic                 live_q;
  logic [PA_W-1:0]      tag_q;
  logic [WIN_BYTES-1:0] mask_q;

  // Activity flag: set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)        live_q <= 1'b0;
    else if (set_i) live_q <= 1'b1;
    else if (clr_i) live_q <= 1'b0;
  end

  // Payload has no reset; it only counts while live_q is set
  always_ff @(posedge clk) begin
    if (set_i) begin
      tag_q  <= tag_i;
      mask_q <= mask_i;
    end
  end

  assign live_o = live_q;
  assign tag_o  = tag_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/lsovl_pair_cmp.sv
module lsovl_pair_cmp
  import lsovl_pkg::*;
#(
  parameter int PA_W = 8
) (
  input  logic                 a_live_i,
  input  logic [PA_W-1:0]      a_tag_i,
  input  logic [WIN_BYTES-1:0] a_mask_i,
  input  logic                 b_live_i,
  input  logic [PA_W-1:0]      b_tag_i,
  input  logic [WIN_BYTES-1:0] b_mask_i,
  output logic                 clash_o
);

  logic same_tag;
  logic byte_hit;

  always_comb begin
    same_tag = (a_tag_i == b_tag_i);
    byte_hit = |(a_mask_i & b_mask_i);
    clash_o  = a_live_i & b_live_i & same_tag & byte_hit;
  end

endmodule

// File: rtl/lsovl_detect.sv
module lsovl_detect
  import lsovl_pkg::*;
#(
  parameter int N_SLOT = 4,
  parameter int PA_W   = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N_SLOT-1:0]               act_i,
  input  logic [N_SLOT-1:0]               rel_i,
  input  logic [N_SLOT*(PA_W+OFF_W)-1:0]  addr_i,
  input  logic [2*N_SLOT-1:0]             size_i,
  output logic [N_SLOT-1:0]               clear_o,
  output logic [N_SLOT*N_SLOT-1:0]        pair_free_o
);

  localparam int AW = PA_W + OFF_W;

  logic [N_SLOT-1:0]    live;
  logic [PA_W-1:0]      tag_q  [N_SLOT];
  logic [WIN_BYTES-1:0] mask_q [N_SLOT];
  logic [WIN_BYTES-1:0] mask_d [N_SLOT];

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    logic [AW-1:0] a_k;
    assign a_k = addr_i[k*AW +: AW];

    lsovl_mask_gen u_mask (
      .off_i  (a_k[OFF_W-1:0]),
      .size_i (acc_size_e'(size_i[k*2 +: 2])),
      .mask_o (mask_d[k])
    );

    lsovl_slot #(.PA_W(PA_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .set_i  (act_i[k]),
      .clr_i  (rel_i[k]),
      .tag_i  (a_k[AW-1:OFF_W]),
      .mask_i (mask_d[k]),
      .live_o (live[k]),
      .tag_o  (tag_q[k]),
      .mask_o (mask_q[k])
    );
  end

  for (genvar i = 0; i < N_SLOT; i++) begin : g_row
    for (genvar j = 0; j < N_SLOT; j++) begin : g_col
      if (i == j) begin : g_self
        assign pair_free_o[i*N_SLOT+j] = live[j];
      end else begin : g_other
        logic clash;
        lsovl_pair_cmp #(.PA_W(PA_W)) u_cmp (
          .a_live_i (live[i]),
          .a_tag_i  (tag_q[i]),
          .a_mask_i (mask_q[i]),
          .b_live_i (live[j]),
          .b_tag_i  (tag_q[j]),
          .b_mask_i (mask_q[j]),
          .clash_o  (clash)
        );
        assign pair_free_o[i*N_SLOT+j] = live[j] & ~clash;
      end
    end
    assign clear_o[i] = live[i] & (pair_free_o[i*N_SLOT +: N_SLOT] == live);
  end

endmodule

// File: rtl/lsovl_detect_chk.sv
module lsovl_detect_chk #(
  parameter int N_SLOT = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic [N_SLOT-1:0]        act_i,
  input logic [N_SLOT-1:0]        rel_i,
  input logic [N_SLOT-1:0]        clear_o,
  input logic [N_SLOT*N_SLOT-1:0] pair_free_o
);

  logic [N_SLOT-1:0] diag;

  always_comb begin
    for (int k = 0; k < N_SLOT; k++) diag[k] = pair_free_o[k*N_SLOT+k];
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (act_i == '0 && rel_i == '0) |=> ($stable(pair_free_o) && $stable(clear_o)));

  for (genvar k = 0; k < N_SLOT; k++) begin : g_k
    p_act_live_r2: assert property (@(posedge clk) disable iff (rst)
      act_i[k] |=> diag[k]);

    p_rel_drop_r3: assert property (@(posedge clk) disable iff (rst)
      (rel_i[k] && !act_i[k]) |=> !diag[k]);

    p_clear_live_r8: assert property (@(posedge clk) disable iff (rst)
      clear_o[k] |-> diag[k]);

    p_clear_row_r10: assert property (@(posedge clk) disable iff (rst)
      clear_o[k] |-> (pair_free_o[k*N_SLOT +: N_SLOT] == diag));

    for (genvar j = 0; j < N_SLOT; j++) begin : g_j
      p_empty_col_r8: assert property (@(posedge clk) disable iff (rst)
        !diag[j] |-> !pair_free_o[k*N_SLOT+j]);
      if (j > k) begin : g_sym
        p_symmetric_r7: assert property (@(posedge clk) disable iff (rst)
          (diag[k] && diag[j]) |-> (pair_free_o[k*N_SLOT+j] == pair_free_o[j*N_SLOT+k]));
      end
    end
  end

endmodule

bind lsovl_detect lsovl_detect_chk #(.N_SLOT(N_SLOT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .act_i       (act_i),
  .rel_i       (rel_i),
  .clear_o     (clear_o),
  .pair_free_o (pair_free_o)
);

// File: tb/lsovl_detect_bench.sv
`timescale 1ns/1ps
module lsovl_detect_bench;

  localparam int N  = 4;
  localparam int PW = 8;
  localparam int AW = PW + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0]    act = '0;
  logic [N-1:0]    rel = '0;
  logic [N*AW-1:0] addr = '0;
  logic [2*N-1:0]  sz = '0;
  logic [N-1:0]    clr_o;
  logic [N*N-1:0]  pf_o;

  lsovl_detect #(.N_SLOT(N), .PA_W(PW)) u_lsovl_detect (
    .clk(clk), .rst(rst), .act_i(act), .rel_i(rel),
    .addr_i(addr), .size_i(sz), .clear_o(clr_o), .pair_free_o(pf_o)
  );

  bit m_act [N];
  int m_tag [N], m_off [N], m_sz [N];
  int p_tag [N], p_off [N], p_sz [N];
  int total = 0;
  int bad   = 0;

  task automatic load(int s, int tag, int off, int size);
    act[s] = 1'b1;
    addr[s*AW +: AW] = AW'(tag * 16 + off);
    sz[s*2 +: 2] = 2'(size);
    p_tag[s] = tag; p_off[s] = off; p_sz[s] = size;
  endtask

  // Apply strobes at one edge, update the model, return at the next negedge
  task automatic tick();
    for (int s = 0; s < N; s++) begin
      if (act[s]) begin
        m_act[s] = 1'b1; m_tag[s] = p_tag[s]; m_off[s] = p_off[s]; m_sz[s] = p_sz[s];
      end else if (rel[s]) begin
        m_act[s] = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    act = '0;
    rel = '0;
  endtask

  function automatic bit overlap(int i, int j);
    int ei, ej, lo, hi;
    ei = m_off[i] + (1 << m_sz[i]); if (ei > 16) ei = 16;
    ej = m_off[j] + (1 << m_sz[j]); if (ej > 16) ej = 16;
    lo = (m_off[i] > m_off[j]) ? m_off[i] : m_off[j];
    hi = (ei < ej) ? ei : ej;
    return (m_tag[i] == m_tag[j]) && (lo < hi);
  endfunction

  task automatic chk(string req);
    logic [N*N-1:0] epf;
    logic [N-1:0]   ec, av;
    for (int i = 0; i < N; i++) av[i] = m_act[i];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        epf[i*N+j] = m_act[j] && !((i != j) && m_act[i] && overlap(i, j));
    for (int i = 0; i < N; i++) ec[i] = m_act[i] && (epf[i*N +: N] == av);
    total++;
    if (pf_o !== epf) begin
      bad++;
      $display("FAIL %s pair matrix: actual %h expected %h", req, pf_o, epf);
    end
    total++;
    if (clr_o !== ec) begin
      bad++;
      $display("FAIL %s clear vector: actual %b expected %b", req, clr_o, ec);
    end
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) begin m_act[s] = 1'b0; m_tag[s] = 0; m_off[s] = 0; m_sz[s] = 0; end
    repeat (3) @(negedge clk);
    chk("R1");
    rst = 1'b0;
    @(negedge clk);
    chk("R1");

    // Same-tag sweep over every offset/size pair in slots 0 and 1
    for (int o0 = 0; o0 < 16; o0++)
      for (int s0 = 0; s0 < 4; s0++)
        for (int o1 = 0; o1 < 16; o1++)
          for (int s1 = 0; s1 < 4; s1++) begin
            load(0, 5, o0, s0);
            load(1, 5, o1, s1);
            tick();
            if (o0 + (1 << s0) > 16 || o1 + (1 << s1) > 16) chk("R6");
            else if (s0 == 0 && s1 == 0) chk("R4");
            else chk("R5");
          end

    // Different tags never clash, even with identical byte ranges
    for (int o = 0; o < 16; o++)
      for (int s = 0; s < 4; s++) begin
        load(0, 5, o, s);
        load(1, (o % 2 == 0) ? 6 : 5 + 128, o, s);
        tick();
        chk("R7");
      end

    rel = 4'b0011;
    tick();
    chk("R3");

    // Three live slots: 0 and 1 overlap, 2 is clear
    load(0, 9, 0, 3);
    load(1, 9, 4, 2);
    load(2, 9, 8, 3);
    tick();
    chk("R10");
    load(3, 9, 15, 0);
    tick();
    chk("R10");

    // Overwrite a live slot with a different tag
    load(1, 200, 4, 2);
    tick();
    chk("R2");

    // Activate and release in the same cycle: activate wins
    load(2, 9, 0, 0);
    rel[2] = 1'b1;
    tick();
    chk("R3");

    // Stale contents of a released slot cause no clash
    rel[0] = 1'b1;
    tick();
    chk("R8");
    rel = 4'b1111;
    tick();
    chk("R8");

    // A lone live slot only sees its own diagonal
    load(3, 1, 7, 3);
    tick();
    chk("R9");
    tick();
    chk("R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule